// File: doc/BRIEF.md
# Bit-Parallel Propositional Rule Evaluator

This block decides whether a query implication follows from a small base of propositional rules. Each rule is an implication "all premises true implies at least one conclusion true" and is held as two bit vectors, one bit per variable: a premise vector and a conclusion vector. The query has the same two-vector shape. Software writes rules one row at a time through a simple write port, loads the query, and pulses `start`.

While running, the block performs one full rewriting pass per clock cycle over every live row at once. In a pass it clears bits that the query already covers on the same side, drops rows that clash with themselves or with the query across sides, and moves rows that have shrunk to a single bit into the query on the opposite side. The run stops with a YES verdict as soon as a live row becomes completely empty or the query holds the same variable on both sides. It stops with NO (not proven) when a pass changes nothing. Evaluation rewrites the stored rows in place, so the rule base is reloaded before the next query.

Top module: `rule_eval_top`

## Requirements
- R1: Bit i of a premise or conclusion vector stands for variable i. While idle, a `wr_en` cycle stores `wr_lhs`/`wr_rhs` into row `wr_idx` with its live flag set to `wr_live`; rows whose live flag is 0 take no part in evaluation.
- R2: In every pass, each live row loses every premise bit that is set in the query premises and every conclusion bit that is set in the query conclusions.
- R3: A live row left with exactly one set bit after clearing is removed, and that bit is OR-ed into the query on the opposite side (a premise bit into the query conclusions, a conclusion bit into the query premises).
- R4: If any live row, after clearing and not discarded, has no bit set on either side, the run ends with `result` = 1.
- R5: A live row whose premise and conclusion vectors share a set bit is discarded.
- R6: A live row is discarded when one of its premise bits is set in the query conclusions, or one of its conclusion bits is set in the query premises.
- R7: A pass that changes no row bit, no live flag and no query bit ends the run with `result` = 0.
- R8: When `start` is accepted and the stored query already has a bit set on both sides, `done` and `result` = 1 appear after that single edge and `busy` never rises; a query that gains such a bit during a run ends it with `result` = 1 at the next pass.
- R9: `busy` is high from the edge that accepts `start` until the edge that ends the run; `done` is high for exactly one cycle, with `busy` low; `result` is held until the next accepted `start`. A run that ends after its k-th pass raises `done` k+1 edges after `start` is sampled.
- R10: While `busy` is high, `start`, `wr_en` and `qry_load` are ignored. `start` uses the query stored by earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Rule row write strobe |
| wr_idx | input | IDXW | Rule row index |
| wr_lhs | input | NV | Premise vector to write |
| wr_rhs | input | NV | Conclusion vector to write |
| wr_live | input | 1 | Live flag to write |
| qry_load | input | 1 | Query load strobe |
| qry_lhs | input | NV | Query premise vector |
| qry_rhs | input | NV | Query conclusion vector |
| start | input | 1 | Begin evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 1 | Verdict: 1 = proven, 0 = not proven |

## Verification
The assertions take for granted that rows and the query change only through the ports while idle, so live flags can only fall and query bits can only rise during a run, and that `start` is sampled against a query already stored. The stimulus therefore reloads the full rule base and the query before each start, keeps random rows sparse so that runs take several passes, and drives writes, query loads and a second start during a run only to show they are ignored.

// File: rtl/rule_eval_pkg.sv
package rule_eval_pkg;
    localparam int DEF_VARS = 8;
    localparam int DEF_ROWS = 8;

    typedef enum logic {
        VERDICT_NO  = 1'b0,
        VERDICT_YES = 1'b1
    } verdict_e;
endpackage

// File: rtl/rule_row_step.sv
module rule_row_step #(
    parameter int NV = 8
) (
    input  logic [NV-1:0] lhs,
    input  logic [NV-1:0] rhs,
    input  logic          live,
    input  logic [NV-1:0] q_lhs,
    input  logic [NV-1:0] q_rhs,
    output logic [NV-1:0] nxt_lhs,
    output logic [NV-1:0] nxt_rhs,
    output logic          nxt_live,
    output logic          is_empty,
    output logic [NV-1:0] give_lhs,
    output logic [NV-1:0] give_rhs,
    output logic          moved
);
    logic [NV-1:0] cut_l, cut_r;
    logic          clash, single;

    always_comb begin
        cut_l  = lhs & ~q_lhs;
        cut_r  = rhs & ~q_rhs;
        clash  = live && (((cut_l & cut_r) | (cut_l & q_rhs) | (cut_r & q_lhs)) != '0);
        single = ($countones({cut_l, cut_r}) == 1);

        is_empty = live && !clash && (cut_l == '0) && (cut_r == '0);
        nxt_live = live && !clash && !single;
        give_lhs = (live && !clash && single) ? cut_r : '0;
        give_rhs = (live && !clash && single) ? cut_l : '0;
        nxt_lhs  = live ? cut_l : lhs;
        nxt_rhs  = live ? cut_r : rhs;
        moved    = live && (clash || single || (cut_l != lhs) || (cut_r != rhs));
    end

    // a_r3_xfer_single: a transfer carries exactly one bit
    always_comb begin
        if ((give_lhs | give_rhs) != '0) begin
            a_r3_xfer_single: assert ($countones({give_lhs, give_rhs}) == 1 && !nxt_live);
        end
    end
endmodule

// File: rtl/rule_or_fold.sv
module rule_or_fold #(
    parameter int NR = 8,
    parameter int NV = 8
) (
    input  logic [NR-1:0][NV-1:0] give_l,
    input  logic [NR-1:0][NV-1:0] give_r,
    input  logic [NR-1:0]         empty,
    input  logic [NR-1:0]         moved,
    output logic [NV-1:0]         all_l,
    output logic [NV-1:0]         all_r,
    output logic                  any_empty,
    output logic                  any_moved
);
    always_comb begin
        all_l = '0;
        all_r = '0;
        for (int i = 0; i < NR; i++) begin
            all_l = all_l | give_l[i];
            all_r = all_r | give_r[i];
        end
        any_empty = |empty;
        any_moved = |moved;
    end
endmodule

// File: rtl/rule_eval_top.sv
module rule_eval_top
    import rule_eval_pkg::*;
#(
    parameter int NV   = DEF_VARS,
    parameter int NR   = DEF_ROWS,
    parameter int IDXW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [NV-1:0]   wr_lhs,
    input  logic [NV-1:0]   wr_rhs,
    input  logic            wr_live,
    input  logic            qry_load,
    input  logic [NV-1:0]   qry_lhs,
    input  logic [NV-1:0]   qry_rhs,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic            result
);
    typedef struct packed {
        logic [NR-1:0][NV-1:0] lhs;
        logic [NR-1:0][NV-1:0] rhs;
        logic [NR-1:0]         live;
        logic [NV-1:0]         ql;
        logic [NV-1:0]         qr;
        logic                  busy;
        logic                  done;
        verdict_e              result;
    } state_t;

    state_t s_q, s_d;

    logic [NR-1:0][NV-1:0] step_l, step_r, give_l, give_r;
    logic [NR-1:0]         step_live, row_empty, row_moved;
    logic [NV-1:0]         add_l, add_r;
    logic                  any_empty, any_moved, q_clash;

    for (genvar g = 0; g < NR; g++) begin : g_row
        rule_row_step #(.NV(NV)) u_step (
            .lhs      (s_q.lhs[g]),
            .rhs      (s_q.rhs[g]),
            .live     (s_q.live[g]),
            .q_lhs    (s_q.ql),
            .q_rhs    (s_q.qr),
            .nxt_lhs  (step_l[g]),
            .nxt_rhs  (step_r[g]),
            .nxt_live (step_live[g]),
            .is_empty (row_empty[g]),
            .give_lhs (give_l[g]),
            .give_rhs (give_r[g]),
            .moved    (row_moved[g])
        );
    end

    rule_or_fold #(.NR(NR), .NV(NV)) u_fold (
        .give_l    (give_l),
        .give_r    (give_r),
        .empty     (row_empty),
        .moved     (row_moved),
        .all_l     (add_l),
        .all_r     (add_r),
        .any_empty (any_empty),
        .any_moved (any_moved)
    );

    assign q_clash = (s_q.ql & s_q.qr) != '0;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (wr_en && (int'(wr_idx) < NR)) begin
                s_d.lhs[wr_idx]  = wr_lhs;
                s_d.rhs[wr_idx]  = wr_rhs;
                s_d.live[wr_idx] = wr_live;
            end
            if (qry_load) begin
                s_d.ql = qry_lhs;
                s_d.qr = qry_rhs;
            end
            if (start) begin
                if (q_clash) begin
                    s_d.done   = 1'b1;
                    s_d.result = VERDICT_YES;
                end else begin
                    s_d.busy   = 1'b1;
                    s_d.result = VERDICT_NO;
                end
            end
        end else if (any_empty || q_clash) begin
            s_d.busy   = 1'b0;
            s_d.done   = 1'b1;
            s_d.result = VERDICT_YES;
        end else if (!any_moved) begin
            s_d.busy   = 1'b0;
            s_d.done   = 1'b1;
            s_d.result = VERDICT_NO;
        end else begin
            s_d.lhs  = step_l;
            s_d.rhs  = step_r;
            s_d.live = step_live;
            s_d.ql   = s_q.ql | add_l;
            s_d.qr   = s_q.qr | add_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign result = s_q.result;

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r8_fast_yes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && q_clash) |=> (done && result && !busy));
    a_r10_live_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((s_q.live & ~$past(s_q.live)) == '0));
    a_r3_query_grows: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((($past(s_q.ql) & ~s_q.ql) == '0) && (($past(s_q.qr) & ~s_q.qr) == '0)));
    a_r7_stall_no: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !any_empty && !q_clash && !any_moved) |=> (done && !result));
    a_r4_empty_yes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && any_empty) |=> (done && result));
endmodule

// File: tb/rule_eval_top_test.sv
module rule_eval_top_test;
    localparam int NV = 8;
    localparam int NR = 8;
    localparam int IDXW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [IDXW-1:0] wr_idx = '0;
    logic [NV-1:0]   wr_lhs = '0, wr_rhs = '0;
    logic            wr_live = 1'b0;
    logic            qry_load = 1'b0;
    logic [NV-1:0]   qry_lhs = '0, qry_rhs = '0;
    logic            start = 1'b0;
    logic            busy, done, result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [NV-1:0] m_l [NR];
    logic [NV-1:0] m_r [NR];
    bit            m_v [NR];
    logic [NV-1:0] m_ql, m_qr;

    rule_eval_top #(.NV(NV), .NR(NR)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_lhs(wr_lhs), .wr_rhs(wr_rhs), .wr_live(wr_live),
        .qry_load(qry_load), .qry_lhs(qry_lhs), .qry_rhs(qry_rhs),
        .start(start), .busy(busy), .done(done), .result(result)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference evaluation built from the requirements.
    function automatic bit model_eval(output int npass);
        logic [NV-1:0] l [NR];
        logic [NV-1:0] r [NR];
        bit            v [NR];
        logic [NV-1:0] ql, qr, al, ar, cl, cr;
        bit            chg;
        for (int i = 0; i < NR; i++) begin l[i] = m_l[i]; r[i] = m_r[i]; v[i] = m_v[i]; end
        ql = m_ql; qr = m_qr;
        npass = 0;
        if ((ql & qr) != '0) return 1'b1;
        for (int p = 0; p < 4000; p++) begin
            npass++;
            if ((ql & qr) != '0) return 1'b1;
            chg = 1'b0; al = '0; ar = '0;
            for (int i = 0; i < NR; i++) begin
                if (v[i]) begin
                    cl = l[i] & ~ql;
                    cr = r[i] & ~qr;
                    if (((cl & cr) | (cl & qr) | (cr & ql)) != '0) begin
                        v[i] = 1'b0; chg = 1'b1;
                    end else if (cl == '0 && cr == '0) begin
                        return 1'b1;
                    end else if ($countones({cl, cr}) == 1) begin
                        al |= cr; ar |= cl; v[i] = 1'b0; chg = 1'b1;
                    end else begin
                        if (cl != l[i] || cr != r[i]) chg = 1'b1;
                        l[i] = cl; r[i] = cr;
                    end
                end
            end
            if (!chg) return 1'b0;
            ql |= al; qr |= ar;
        end
        return 1'b0;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < NR; i++) begin m_l[i] = '0; m_r[i] = '0; m_v[i] = 1'b0; end
        m_ql = '0; m_qr = '0;
    endtask

    task automatic load_all();
        for (int i = 0; i < NR; i++) begin
            wr_en = 1'b1; wr_idx = IDXW'(i); wr_lhs = m_l[i]; wr_rhs = m_r[i]; wr_live = m_v[i];
            @(negedge clk);
        end
        wr_en = 1'b0;
        qry_load = 1'b1; qry_lhs = m_ql; qry_rhs = m_qr;
        @(negedge clk);
        qry_load = 1'b0;
    endtask

    task automatic run_and_check(input string req, input bit check_lat);
        bit exp_res;
        int npass, lat, got;
        exp_res = model_eval(npass);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 5000) begin @(negedge clk); lat++; end
        got = int'(result);
        check(done === 1'b1, {req, " done seen"}, int'(done), 1);
        check(got == int'(exp_res), {req, " verdict"}, got, int'(exp_res));
        check(busy === 1'b0, "R9 busy low at done", int'(busy), 0);
        if (check_lat) check(lat == npass + 1, "R9 latency", lat, npass + 1);
        @(negedge clk);
        check(done === 1'b0, "R9 done one cycle", int'(done), 0);
        check(result == exp_res, "R9 result held", int'(result), int'(exp_res));
    endtask

    function automatic logic [NV-1:0] sparse();
        return NV'($urandom & $urandom & $urandom);
    endfunction

    initial begin
        int seed_dummy;
        int npass;
        seed_dummy = $urandom(32'd2718);
        clear_model();
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && result === 1'b0, "R9 reset state",
              int'({busy, done, result}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: worked example, variable A = bit 0 .. H = bit 7
        clear_model();
        m_l[0] = 8'h06; m_r[0] = 8'h80; m_v[0] = 1;
        m_l[1] = 8'h30; m_r[1] = 8'h0C; m_v[1] = 1;
        m_l[2] = 8'h04; m_r[2] = 8'h30; m_v[2] = 1;
        m_l[3] = 8'h02; m_r[3] = 8'h20; m_v[3] = 1;
        m_l[4] = 8'h08; m_r[4] = 8'h02; m_v[4] = 1;
        m_l[5] = 8'h08; m_r[5] = 8'h04; m_v[5] = 1;
        m_l[6] = 8'h10; m_r[6] = 8'h24; m_v[6] = 1;
        m_ql = 8'h08; m_qr = 8'h80;
        load_all();
        check(model_eval(npass) == 1'b1 && npass == 2, "R3 example model", npass, 2);
        run_and_check("R3 R4 example", 1'b1);

        // R2: clearing alone empties a row
        clear_model();
        m_l[2] = 8'h05; m_v[2] = 1; m_ql = 8'h05;
        load_all();
        run_and_check("R2 clear to empty", 1'b1);

        // R1: a dead empty row is ignored, a live one proves
        clear_model();
        m_ql = 8'h01; m_qr = 8'h02; m_v[6] = 0;
        load_all();
        run_and_check("R1 dead row ignored", 1'b1);
        clear_model();
        m_ql = 8'h01; m_qr = 8'h02; m_v[6] = 1;
        load_all();
        run_and_check("R4 live empty row", 1'b1);

        // R5: self-clashing row dropped
        clear_model();
        m_l[0] = 8'h11; m_r[0] = 8'h01; m_v[0] = 1;
        load_all();
        run_and_check("R5 self clash", 1'b1);

        // R6: cross clash with query, both directions
        clear_model();
        m_r[1] = 8'h0C; m_v[1] = 1; m_l[3] = 8'h60; m_r[3] = 8'h01; m_v[3] = 1;
        m_ql = 8'h04; m_qr = 8'h40;
        load_all();
        run_and_check("R6 cross clash", 1'b1);

        // R7: no rules, stalls at first pass
        clear_model();
        m_ql = 8'h01; m_qr = 8'h02;
        load_all();
        run_and_check("R7 stall", 1'b1);

        // R8: overlapping query answers after one edge
        clear_model();
        m_ql = 8'h90; m_qr = 8'h10;
        load_all();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1 && result === 1'b1 && busy === 1'b0, "R8 immediate yes",
              int'({done, result, busy}), 6);
        @(negedge clk);

        // R10: writes, query load and start during a run are ignored
        clear_model();
        m_l[0] = 8'h07; m_r[0] = 8'h04; m_v[0] = 1;
        m_l[0] = 8'h03; m_r[0] = 8'h04;
        m_ql = 8'h01;
        load_all();
        begin
            bit exp_res;
            int lat;
            exp_res = model_eval(npass);
            start = 1'b1;
            @(negedge clk);
            check(busy === 1'b1, "R9 busy after start", int'(busy), 1);
            wr_en = 1'b1; wr_idx = 3'd5; wr_lhs = '0; wr_rhs = '0; wr_live = 1'b1;
            qry_load = 1'b1; qry_lhs = 8'hFF; qry_rhs = 8'hFF;
            @(negedge clk);
            wr_en = 1'b0; qry_load = 1'b0; start = 1'b0;
            lat = 2;
            while (!done && lat < 5000) begin @(negedge clk); lat++; end
            check(result == exp_res && exp_res == 1'b0, "R10 inputs ignored while busy",
                  int'(result), 0);
            check(lat == npass + 1, "R10 latency unchanged", lat, npass + 1);
            @(negedge clk);
            check(done === 1'b0 && busy === 1'b0, "R10 second start ignored",
                  int'({done, busy}), 0);
        end

        // Random rule bases, checked against the reference model
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < NR; i++) begin
                m_l[i] = sparse() | NV'($urandom & $urandom);
                m_r[i] = sparse();
                m_v[i] = ($urandom % 4) != 0;
            end
            m_ql = sparse();
            m_qr = sparse();
            if (($urandom % 3) != 0) m_qr = m_qr & ~m_ql;
            load_all();
            run_and_check("R2 R3 R4 R5 R6 R7 random", 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule